// File: doc/BRIEF.md
# Arbitrary Waveform Playback Sequencer

This block produces the read addresses for the sample memory of an arbitrary waveform source. A small table describes the playback. Every step of the table points at one waveform segment, given as a base address and a sample count, and says how often that segment is replayed: a fixed number of passes, or forever. While it plays, the block walks the table and presents one sample address per clock together with a valid strobe and the index of the step in use. Every output channel reads the same address stream, so all channels stay in lockstep.

A two-bit mode input selects what starts and ends playback:
- **Loop** (0): plays the table again and again while running.
- **Shot** (1): plays the table once for each trigger pulse.
- **Gated** (2): loops while a gate level is high and falls back to the start as soon as the gate drops.
- **Script** (3): plays the table once each time the run enable is raised.

The one-pass modes (shot and script) signal the end of the table with a one-cycle done pulse. Entries are loaded through a write port. Each written length is checked, and an illegal segment is reported at once and is never played.

Top module: `awg_seq_player`

## Requirements
- R1: A written entry is legal only when its length lies in 256..4,194,048 and its two low bits are zero. Writing an illegal entry raises `wr_err_o` for exactly the cycle after the write. Writing a legal entry leaves `wr_err_o` low.
- R2: While a legal step plays, `valid_o` is high and `addr_o` equals (base + offset) modulo 2^ADDR_W. The offset runs 0, 1, …, length-1, one sample per clock.
- R3: A step whose infinite bit is clear plays its segment N times before moving on. N is the 16-bit repeat field, and a field value of 0 means 65,536 passes.
- R4: A step whose infinite bit is set repeats its segment without end and never advances to the next step.
- R5: A step whose entry was flagged illegal emits no samples. It occupies exactly one cycle, with `valid_o` low and `step_o` showing that step, and then the walk moves on.
- R6: In loop mode (mode 0), playback starts on the first clock edge with `run_i` high. After the step at `last_step_i` finishes, the next cycle plays step 0, offset 0, with no gap.
- R7: In shot mode (mode 1), a `trig_i` pulse seen in idle with `run_i` high starts one pass through the table. A `trig_i` that arrives during that pass has no effect.
- R8: In gated mode (mode 2), playback starts when `gate_i` and `run_i` are both high and loops like mode 0. One cycle after `gate_i` goes low, `valid_o` is low and `step_o` is 0. The next rise of `gate_i` restarts from step 0, offset 0.
- R9: In script mode (mode 3), one pass starts only on a rising edge of `run_i`. Holding `run_i` high after the pass does not start another.
- R10: In modes 1 and 3, the cycle after the last sample of the pass shows `done_o` high for exactly one cycle, with `valid_o` low and `step_o` at 0.
- R11: In any mode, one cycle after `run_i` is low, `valid_o` is low and `step_o` is 0.
- R12: After reset, `valid_o`, `done_o` and `wr_err_o` are low, `step_o` is 0, and every table entry is marked illegal until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Playback mode: 0 loop, 1 shot, 2 gated, 3 script |
| run_i | input | 1 | Run enable |
| trig_i | input | 1 | Trigger pulse (mode 1) |
| gate_i | input | 1 | Gate level (mode 2) |
| last_step_i | input | IDX_W | Index of the final table step |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry written |
| wr_start_i | input | ADDR_W | Segment base address |
| wr_len_i | input | ADDR_W | Segment length in samples |
| wr_rep_i | input | 16 | Repeat count, 0 means 65,536 |
| wr_inf_i | input | 1 | Repeat the segment without end |
| wr_err_o | output | 1 | Illegal entry written, pulsed the cycle after the write |
| addr_o | output | ADDR_W | Sample memory read address |
| valid_o | output | 1 | `addr_o` carries a sample this cycle |
| step_o | output | IDX_W | Table step in use |
| done_o | output | 1 | One-pass playback finished |

## Verification
The assertions assume three things about the inputs. The table is not rewritten while playback is active. The mode and the final step index stay constant during a run. The final step index names a stored entry. The address-increment property depends on the first of these: an offset other than zero implies the previous cycle played the same entry. The stimulus writes entries, changes the mode and moves the final index only while `run_i` is low and the block is idle. Random tables mix legal lengths, illegal lengths and small repeat counts within those limits, and directed cases cover an infinite step, a zero repeat field, the gate drop, and a trigger during a pass.

// File: rtl/awg_seq_pkg.sv
// Package: shared mode and state encodings for the playback sequencer.
// Assumes: modes arrive as a 2-bit code from the block's mode input.
package awg_seq_pkg;
    typedef enum logic [1:0] {
        MODE_LOOP   = 2'd0,
        MODE_SHOT   = 2'd1,
        MODE_GATED  = 2'd2,
        MODE_SCRIPT = 2'd3
    } play_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

    localparam int unsigned REP_W  = 16;
    localparam int unsigned PASS_W = REP_W + 1;
endpackage

// File: rtl/awg_seq_table.sv
// Module: step table storage with a length legality check at write time.
// Assumes: DEPTH is a power of two so every read index names an entry;
// entries written past DEPTH are dropped.
module awg_seq_table #(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int ADDR_W  = 22,
    parameter int MIN_LEN = 256,
    parameter int MAX_LEN = 4194048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_len,
    input  logic [15:0]       wr_rep,
    input  logic              wr_inf,
    output logic              wr_err,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_len,
    output logic [15:0]       rd_rep,
    output logic              rd_inf,
    output logic              rd_ok
);
    localparam logic [IDX_W:0]    DEPTH_L = (IDX_W+1)'(DEPTH);
    localparam logic [ADDR_W-1:0] LEN_LO  = ADDR_W'(MIN_LEN);
    localparam logic [ADDR_W-1:0] LEN_HI  = ADDR_W'(MAX_LEN);

    logic [ADDR_W-1:0] start_q [DEPTH];
    logic [ADDR_W-1:0] len_q   [DEPTH];
    logic [15:0]       rep_q   [DEPTH];
    logic [DEPTH-1:0]  inf_q;
    logic [DEPTH-1:0]  ok_q;
    logic              legal;
    logic              in_range;

    // Legal length: inside the bounds and a whole number of 4-sample groups.
    always_comb begin
        legal    = (wr_len >= LEN_LO) && (wr_len <= LEN_HI) && (wr_len[1:0] == 2'b00);
        in_range = {1'b0, wr_idx} < DEPTH_L;
    end

    // Segment data storage; no reset needed since ok_q gates its use.
    always_ff @(posedge clk) begin
        if (wr_en && in_range) begin
            start_q[wr_idx] <= wr_start;
            len_q[wr_idx]   <= wr_len;
            rep_q[wr_idx]   <= wr_rep;
        end
    end

    // Legality flags, infinite flags and the write error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= '0;
            inf_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !legal;
            if (wr_en && in_range) begin
                ok_q[wr_idx]  <= legal;
                inf_q[wr_idx] <= wr_inf;
            end
        end
    end

    // Combinational read of the entry in use.
    always_comb begin
        rd_start = start_q[rd_idx];
        rd_len   = len_q[rd_idx];
        rd_rep   = rep_q[rd_idx];
        rd_inf   = inf_q[rd_idx];
        rd_ok    = ok_q[rd_idx];
    end

    // R1: an error pulse always follows a write strobe.
    a_r1_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));
endmodule

// File: rtl/awg_seq_walker.sv
// Module: playback state machine that walks table steps, counts passes and
// offsets, and applies the start/stop rules of the four modes.
// Assumes: table, mode and last step are held steady while playing.
module awg_seq_walker
    import awg_seq_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              run_i,
    input  logic              trig_i,
    input  logic              gate_i,
    input  logic [IDX_W-1:0]  last_step_i,
    input  logic [ADDR_W-1:0] ent_start,
    input  logic [ADDR_W-1:0] ent_len,
    input  logic [15:0]       ent_rep,
    input  logic              ent_inf,
    input  logic              ent_ok,
    output logic [IDX_W-1:0]  step_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              done_o
);
    localparam logic [PASS_W-1:0] FULL_REP = PASS_W'(1) << REP_W;

    play_mode_e        mode;
    play_state_e       state_q;
    logic [IDX_W-1:0]  step_q;
    logic [ADDR_W-1:0] offs_q;
    logic [PASS_W-1:0] pass_q;
    logic [PASS_W-1:0] rep_target;
    logic              run_q;
    logic              done_q;
    logic              seg_end, step_end, seq_end, one_pass, start_ok, stop;

    assign mode = play_mode_e'(mode_i);

    // Step, segment and sequence end conditions plus mode start/stop rules.
    always_comb begin
        rep_target = (ent_rep == 16'd0) ? FULL_REP : {1'b0, ent_rep};
        seg_end    = (offs_q == ent_len - ADDR_W'(1));
        step_end   = !ent_ok || (seg_end && !ent_inf && (pass_q + PASS_W'(1) == rep_target));
        seq_end    = step_end && (step_q == last_step_i);
        one_pass   = (mode == MODE_SHOT) || (mode == MODE_SCRIPT);
        stop       = !run_i || ((mode == MODE_GATED) && !gate_i);
        unique case (mode)
            MODE_LOOP:   start_ok = run_i;
            MODE_SHOT:   start_ok = run_i && trig_i;
            MODE_GATED:  start_ok = run_i && gate_i;
            MODE_SCRIPT: start_ok = run_i && !run_q;
            default:     start_ok = 1'b0;
        endcase
    end

    // Playback state, counters and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            offs_q  <= '0;
            pass_q  <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            run_q  <= run_i;
            if (state_q == ST_IDLE) begin
                step_q <= '0;
                offs_q <= '0;
                pass_q <= '0;
                if (start_ok) state_q <= ST_PLAY;
            end else if (stop) begin
                state_q <= ST_IDLE;
                step_q  <= '0;
                offs_q  <= '0;
                pass_q  <= '0;
            end else if (step_end) begin
                offs_q <= '0;
                pass_q <= '0;
                if (seq_end) begin
                    step_q <= '0;
                    if (one_pass) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end else begin
                    step_q <= step_q + IDX_W'(1);
                end
            end else if (seg_end) begin
                offs_q <= '0;
                pass_q <= ent_inf ? '0 : pass_q + PASS_W'(1);
            end else begin
                offs_q <= offs_q + ADDR_W'(1);
            end
        end
    end

    // Outputs derived from the walker state and the entry in use.
    always_comb begin
        step_o  = step_q;
        addr_o  = ent_start + offs_q;
        valid_o = (state_q == ST_PLAY) && ent_ok;
        done_o  = done_q;
    end

    // R2: inside a segment, consecutive samples have consecutive addresses.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && offs_q != '0) |-> (addr_o == $past(addr_o) + ADDR_W'(1)));
    // R10: done lasts exactly one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: done coincides with idle output at step 0.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!valid_o && step_o == '0));
    // R11: dropping run silences the output on the next cycle.
    a_r11_run_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!valid_o && step_o == '0));
    // R8: a low gate in gated mode silences the output on the next cycle.
    a_r8_gate_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GATED && !gate_i) |=> !valid_o);
endmodule

// File: rtl/awg_seq_player.sv
// Module: top of the playback sequencer; joins the step table and walker.
// Assumes: one address stream feeds all output channels in lockstep.
module awg_seq_player #(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int ADDR_W  = 22,
    parameter int MIN_LEN = 256,
    parameter int MAX_LEN = 4194048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              run_i,
    input  logic              trig_i,
    input  logic              gate_i,
    input  logic [IDX_W-1:0]  last_step_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_start_i,
    input  logic [ADDR_W-1:0] wr_len_i,
    input  logic [15:0]       wr_rep_i,
    input  logic              wr_inf_i,
    output logic              wr_err_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic [IDX_W-1:0]  step_o,
    output logic              done_o
);
    logic [ADDR_W-1:0] ent_start, ent_len;
    logic [15:0]       ent_rep;
    logic              ent_inf, ent_ok;

    awg_seq_table #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_idx(wr_idx_i), .wr_start(wr_start_i),
        .wr_len(wr_len_i), .wr_rep(wr_rep_i), .wr_inf(wr_inf_i),
        .wr_err(wr_err_o),
        .rd_idx(step_o), .rd_start(ent_start), .rd_len(ent_len),
        .rd_rep(ent_rep), .rd_inf(ent_inf), .rd_ok(ent_ok)
    );

    awg_seq_walker #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) walker_i (
        .clk(clk), .rst_n(rst_n),
        .mode_i(mode_i), .run_i(run_i), .trig_i(trig_i), .gate_i(gate_i),
        .last_step_i(last_step_i),
        .ent_start(ent_start), .ent_len(ent_len), .ent_rep(ent_rep),
        .ent_inf(ent_inf), .ent_ok(ent_ok),
        .step_o(step_o), .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o)
    );
endmodule

// File: tb/awg_seq_player_tb_top.sv
// Bench: directed corner cases plus seeded random tables, checked against
// an expected sample stream built from the bench's own copy of the table.
module awg_seq_player_tb_top;
    localparam int ADDR_W = 22;
    localparam int IDX_W  = 4;
    localparam int MAXS   = 16384;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = 2'd0;
    logic              run_i = 1'b0, trig_i = 1'b0, gate_i = 1'b0;
    logic [IDX_W-1:0]  last_step_i = '0;
    logic              wr_en_i = 1'b0;
    logic [IDX_W-1:0]  wr_idx_i = '0;
    logic [ADDR_W-1:0] wr_start_i = '0, wr_len_i = '0;
    logic [15:0]       wr_rep_i = '0;
    logic              wr_inf_i = 1'b0;
    logic              wr_err_o, valid_o, done_o;
    logic [ADDR_W-1:0] addr_o;
    logic [IDX_W-1:0]  step_o;

    int n_chk = 0, n_err = 0;
    int tb_start [16];
    int tb_len   [16];
    int tb_rep   [16];
    int exp_addr [MAXS];
    int exp_step [MAXS];
    bit exp_vld  [MAXS];

    awg_seq_player dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .run_i(run_i),
        .trig_i(trig_i), .gate_i(gate_i), .last_step_i(last_step_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_start_i(wr_start_i),
        .wr_len_i(wr_len_i), .wr_rep_i(wr_rep_i), .wr_inf_i(wr_inf_i),
        .wr_err_o(wr_err_o), .addr_o(addr_o), .valid_o(valid_o),
        .step_o(step_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_legal(input int len);
        return (len >= 256) && (len <= 4194048) && (len % 4 == 0);
    endfunction

    // Expected stream for one pass through steps 0..last (finite repeats only).
    function automatic int build_stream(input int last);
        int n = 0;
        for (int s = 0; s <= last; s++) begin
            if (!is_legal(tb_len[s])) begin
                exp_vld[n] = 1'b0; exp_step[n] = s; exp_addr[n] = 0; n++;
            end else begin
                for (int r = 0; r < tb_rep[s]; r++)
                    for (int o = 0; o < tb_len[s]; o++) begin
                        exp_vld[n] = 1'b1; exp_step[n] = s;
                        exp_addr[n] = (tb_start[s] + o) & 32'h3FFFFF; n++;
                    end
            end
        end
        return n;
    endfunction

    // Write one entry and check the error pulse (R1).
    task automatic write_entry(input int idx, input int st, input int len,
                               input int rep, input bit inf);
        wr_en_i = 1'b1; wr_idx_i = IDX_W'(idx); wr_start_i = ADDR_W'(st);
        wr_len_i = ADDR_W'(len); wr_rep_i = 16'(rep); wr_inf_i = inf;
        tb_start[idx] = st; tb_len[idx] = len; tb_rep[idx] = (rep == 0) ? 65536 : rep;
        @(negedge clk);
        wr_en_i = 1'b0;
        chk("R1 wr_err", 32'(wr_err_o), 32'(!is_legal(len)));
    endtask

    // Compare total cycles against a stream of nslots slots, wrapping.
    task automatic check_stream(input int nslots, input int total, input int trig_at);
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            trig_i = 1'b0;
            chk("R2 valid", 32'(valid_o), 32'(exp_vld[k % nslots]));
            if (exp_vld[k % nslots]) chk("R2 addr", 32'(addr_o), exp_addr[k % nslots]);
            chk("R3 R5 step", 32'(step_o), exp_step[k % nslots]);
            if (k == trig_at) trig_i = 1'b1;
        end
    endtask

    task automatic expect_done(input string req);
        @(negedge clk);
        chk({req, " R10 done high"}, 32'(done_o), 1);
        chk("R10 step zero", 32'(step_o), 0);
        chk("R10 valid low", 32'(valid_o), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({req, " no restart"}, 32'(valid_o), 0);
            chk("R10 done single", 32'(done_o), 0);
        end
    endtask

    task automatic stop_run();
        run_i = 1'b0;
        @(negedge clk);
        chk("R11 valid low", 32'(valid_o), 0);
        chk("R11 step zero", 32'(step_o), 0);
        @(negedge clk);
    endtask

    initial begin
        int n, sel, last;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 valid", 32'(valid_o), 0);
        chk("R12 done", 32'(done_o), 0);
        chk("R12 step", 32'(step_o), 0);
        chk("R12 wr_err", 32'(wr_err_o), 0);
        // R12: unwritten entries are illegal, loop plays nothing
        mode_i = 2'd0; last_step_i = '0; run_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R12 empty table", 32'(valid_o), 0);
        end
        stop_run();

        // R1 boundaries
        write_entry(5, 0, 4194048, 1, 0);
        write_entry(5, 0, 4194052, 1, 0);
        write_entry(5, 0, 252, 1, 0);
        write_entry(5, 0, 258, 1, 0);
        write_entry(5, 0, 256, 1, 0);

        // R6: loop with an illegal middle step (R5), two full rounds
        write_entry(0, 100, 256, 2, 0);
        write_entry(1, 5000, 262, 1, 0);
        write_entry(2, 32'h3FFF80, 260, 1, 0);
        last_step_i = 4'd2; mode_i = 2'd0;
        n = build_stream(2);
        run_i = 1'b1;
        check_stream(n, 2 * n, -1);
        stop_run();

        // R7: shot mode, trigger mid pass is ignored
        mode_i = 2'd1; run_i = 1'b1;
        @(negedge clk);
        chk("R7 idle before trigger", 32'(valid_o), 0);
        trig_i = 1'b1;
        @(posedge clk); #1 trig_i = 1'b0;
        check_stream(n, n, 300);
        expect_done("R7");
        stop_run();

        // R9: script mode starts on run rise only
        mode_i = 2'd3; run_i = 1'b1;
        check_stream(n, n, -1);
        expect_done("R9");
        stop_run();

        // R8: gated mode, drop and restart
        mode_i = 2'd2; run_i = 1'b1; gate_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 gate low idle", 32'(valid_o), 0);
        end
        gate_i = 1'b1;
        check_stream(n, n + 50, -1);
        gate_i = 1'b0;
        @(negedge clk);
        chk("R8 gate drop valid", 32'(valid_o), 0);
        chk("R8 gate drop step", 32'(step_o), 0);
        gate_i = 1'b1;
        check_stream(n, 40, -1);
        gate_i = 1'b0;
        stop_run();

        // R4: infinite step in shot mode never ends
        write_entry(0, 777, 256, 1, 1);
        last_step_i = 4'd1; mode_i = 2'd1; run_i = 1'b1;
        for (int o = 0; o < 256; o++) begin
            exp_vld[o] = 1'b1; exp_step[o] = 0; exp_addr[o] = 777 + o;
        end
        trig_i = 1'b1;
        @(posedge clk); #1 trig_i = 1'b0;
        check_stream(256, 700, -1);
        chk("R4 no done", 32'(done_o), 0);
        stop_run();

        // R3: repeat field 0 means 65536 passes; still on step 0 after 3 passes
        write_entry(0, 40, 256, 0, 0);
        mode_i = 2'd0; run_i = 1'b1;
        for (int o = 0; o < 256; o++) exp_addr[o] = 40 + o;
        check_stream(256, 3 * 256 + 10, -1);
        stop_run();

        // Random tables
        for (int it = 0; it < 6; it++) begin
            last = int'($urandom % 4);
            for (int s = 0; s <= last; s++) begin
                sel = int'($urandom % 5);
                write_entry(s, int'($urandom & 32'h3FFFFF),
                            (sel == 0) ? ((($urandom % 2) == 0) ? 258 : 200)
                                       : 256 + 4 * int'($urandom % 16),
                            1 + int'($urandom % 3), 0);
            end
            last_step_i = IDX_W'(last);
            n = build_stream(last);
            sel = int'($urandom % 3);
            if (sel == 0) begin
                mode_i = 2'd0; run_i = 1'b1;
                check_stream(n, 2 * n, -1);
            end else if (sel == 1) begin
                mode_i = 2'd1; run_i = 1'b1;
                @(negedge clk);
                trig_i = 1'b1;
                @(posedge clk); #1 trig_i = 1'b0;
                check_stream(n, n, n / 2);
                expect_done("R7");
            end else begin
                mode_i = 2'd3; run_i = 1'b1;
                check_stream(n, n, -1);
                expect_done("R9");
            end
            stop_run();
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule